// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a NOR flash and waits for a program or erase operation in the device to finish. A single-cycle `start` strobe hands it the byte that was written and the address to poll. That address is the programmed location, or any location inside the sector being erased. The poller then reads that address over a simple request/response read port, one request at a time. It compares the completion bit (bit 7) of each returned byte with bit 7 of the expected byte, and it watches the device's time-limit bit (bit 5).

A bit-7 match ends the wait with a pass. A mismatch with bit 5 clear starts another poll. A mismatch with bit 5 set causes exactly one more read, because bit 7 can settle in the same read that raised bit 5. That final read alone decides pass or fail. A poll-count limit ends the loop with a fail if the device never answers. The result is given as a one-cycle `done` strobe with a `pass` flag. `busy` covers the time in between.

Top module: `flash_poll_engine`

## Requirements
- R1: Every read request is a one-cycle `rdReq` pulse carrying the address latched at start. No new request is issued before the response to the previous one arrives on `rdValid`.
- R2: A response whose bit 7 equals bit 7 of the latched expected byte ends the operation with `pass`=1, whatever bit 5 of that response is.
- R3: A response whose bit 7 mismatches while bit 5 is 0 leads to another read of the same address, unless the poll limit has been reached.
- R4: A response whose bit 7 mismatches while bit 5 is 1 leads to exactly one further read. If that read's bit 7 matches, the result is `pass`=1. If it mismatches, the result is `pass`=0.
- R5: `done` is high for exactly one cycle, in the cycle after the deciding response is sampled. `pass` is valid in that cycle, and `busy` is already low in that cycle.
- R6: `busy` and the first `rdReq` rise in the cycle after an accepted start. `busy` stays high until the `done` cycle.
- R7: After MAX_POLLS main-loop reads that each mismatch on bit 7 with bit 5 clear, the operation ends with `pass`=0 and issues no further reads.
- R8: A `start` while `busy` is high is ignored. The running operation keeps its address, its expected byte and its read count.
- R9: A `rdValid` that arrives while no response is awaited has no effect on `busy`, `done` or `rdReq`.
- R10: After reset, `busy`, `done` and `rdReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (single-cycle strobe, taken only when idle) |
| expData | input | DATA_W | Byte written by the operation being watched |
| validAddr | input | ADDR_W | Address to poll |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | Result, valid while done is high |
| rdReq | output | 1 | Read request strobe toward the flash |
| rdAddr | output | ADDR_W | Read address |
| rdValid | input | 1 | Read response strobe |
| rdData | input | DATA_W | Read response byte |

## Verification
`busy` and the first `rdReq` are due one clock after the edge that samples `start`. `done` and `pass` are due one clock after the edge that samples the deciding `rdValid`, so their latency follows the response latency of the flash model. The model's response latency varies from one to three cycles between cases. The bench drives and samples only on falling edges. It checks `busy` on every cycle between start and completion. It checks `done` in the cycle it rises and again one cycle later, so the single-cycle strobe is confirmed. It counts requests in the model and checks that count against the number of reads each case is due to take.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RECHK_ISSUE,
    ST_RECHK_WAIT
  } pollState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture address and expected byte, clear poll count
    logic cntInc;   // one main-loop read issued
    logic finish;   // produce done next cycle
    logic verdict;  // pass value that goes with finish
  } pollStrobe_t;

endpackage

// File: rtl/flash_poll_dp.sv
module flash_poll_dp
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int MAX_POLLS = 4096,
  parameter int MATCH_BIT = 7,
  parameter int LIMIT_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       strb,
  input  logic [DATA_W-1:0] expData,
  input  logic [ADDR_W-1:0] validAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              dataMatch,
  output logic              limitFlag,
  output logic              limitHit,
  output logic              done,
  output logic              pass
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_POLLS);

  logic [ADDR_W-1:0] addrReg;
  logic              expBit;
  logic [CNT_W-1:0]  pollCnt;
  logic              unusedBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      expBit  <= 1'b0;
    end else if (strb.load) begin
      addrReg <= validAddr;
      expBit  <= expData[MATCH_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            pollCnt <= '0;
    else if (strb.load)   pollCnt <= '0;
    else if (strb.cntInc) pollCnt <= pollCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0;
      pass <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.finish) pass <= strb.verdict;
    end
  end

  assign rdAddr     = addrReg;
  assign dataMatch  = (rdData[MATCH_BIT] == expBit);
  assign limitFlag  = rdData[LIMIT_BIT];
  assign limitHit   = (pollCnt >= CNT_MAX);
  assign unusedBits = ^{expData, rdData};

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= CNT_MAX); // R7
  AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !$past(strb.load)) |=> $stable(rdAddr)); // R8

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rdValid,
  input  logic        dataMatch,
  input  logic        limitFlag,
  input  logic        limitHit,
  output pollStrobe_t strb,
  output logic        rdReq,
  output logic        busy
);

  pollState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          nextState = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strb.cntInc = 1'b1;
        nextState   = ST_WAIT;
      end
      ST_WAIT: begin
        if (rdValid) begin
          if (dataMatch) begin
            strb.finish  = 1'b1;
            strb.verdict = 1'b1;
            nextState    = ST_IDLE;
          end else if (limitFlag) begin
            nextState = ST_RECHK_ISSUE;
          end else if (limitHit) begin
            strb.finish = 1'b1;
            nextState   = ST_IDLE;
          end else begin
            nextState = ST_ISSUE;
          end
        end
      end
      ST_RECHK_ISSUE: nextState = ST_RECHK_WAIT;
      ST_RECHK_WAIT: begin
        if (rdValid) begin
          strb.finish  = 1'b1;
          strb.verdict = dataMatch;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign rdReq = (state == ST_ISSUE) || (state == ST_RECHK_ISSUE);
  assign busy  = (state != ST_IDLE);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq); // R1
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> busy); // R1
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && rdReq)); // R6
  AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !busy); // R5
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> !busy); // R9

endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int MAX_POLLS = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] expData,
  input  logic [ADDR_W-1:0] validAddr,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData
);

  pollStrobe_t strb;
  logic        dataMatch;
  logic        limitFlag;
  logic        limitHit;

  flash_poll_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .rdValid   (rdValid),
    .dataMatch (dataMatch),
    .limitFlag (limitFlag),
    .limitHit  (limitHit),
    .strb      (strb),
    .rdReq     (rdReq),
    .busy      (busy)
  );

  flash_poll_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_POLLS (MAX_POLLS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .expData   (expData),
    .validAddr (validAddr),
    .rdData    (rdData),
    .rdAddr    (rdAddr),
    .dataMatch (dataMatch),
    .limitFlag (limitFlag),
    .limitHit  (limitHit),
    .done      (done),
    .pass      (pass)
  );

endmodule

// File: tb/flash_poll_engine_tb.sv
module flash_poll_engine_tb;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam int MAXP   = 8;

  localparam int NV = 7;
  localparam logic [7:0] V_EXP [NV] = '{8'hA5, 8'h80, 8'h80, 8'h80, 8'h00, 8'h00, 8'h7F};
  localparam logic [7:0] V_RSP [NV][4] = '{
    '{8'hA5, 8'h00, 8'h00, 8'h00},
    '{8'h00, 8'h00, 8'h80, 8'h00},
    '{8'h00, 8'h20, 8'h80, 8'h00},
    '{8'h20, 8'h20, 8'h00, 8'h00},
    '{8'h80, 8'hA0, 8'h20, 8'h00},
    '{8'hA0, 8'h80, 8'h00, 8'h00},
    '{8'h20, 8'h00, 8'h00, 8'h00}};
  localparam int V_LEN   [NV] = '{1, 3, 3, 2, 3, 2, 1};
  localparam int V_LAT   [NV] = '{1, 2, 1, 3, 2, 1, 2};
  localparam bit V_PASS  [NV] = '{1, 1, 1, 0, 1, 0, 1};
  localparam int V_READS [NV] = '{1, 3, 3, 2, 3, 2, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [DATA_W-1:0] expData = '0;
  logic [ADDR_W-1:0] validAddr = '0;
  logic busy, done, pass, rdReq;
  logic [ADDR_W-1:0] rdAddr;
  logic rdValid;
  logic [DATA_W-1:0] rdData;

  logic modelValid = 1'b0;
  logic [DATA_W-1:0] modelData = '0;
  logic stray = 1'b0;
  logic [DATA_W-1:0] strayData = '0;
  logic clearModel = 1'b1;
  logic [7:0] script [4];
  int scriptLen = 1;
  int lat = 1;
  logic [ADDR_W-1:0] curAddr = '0;
  int reqCount = 0;
  int addrErr = 0;
  int rspIdx = 0;
  int waitCnt = 0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  assign rdValid = modelValid | stray;
  assign rdData  = stray ? strayData : modelData;

  flash_poll_engine #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_POLLS (MAXP)
  ) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .expData   (expData),
    .validAddr (validAddr),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .rdReq     (rdReq),
    .rdAddr    (rdAddr),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );

  // Flash model: answers each request after lat cycles
  always @(posedge clk) begin
    modelValid <= 1'b0;
    if (clearModel) begin
      reqCount <= 0;
      addrErr  <= 0;
      rspIdx   <= 0;
      waitCnt  <= 0;
    end else if (rdReq) begin
      reqCount <= reqCount + 1;
      if (rdAddr !== curAddr) addrErr <= addrErr + 1;
      waitCnt <= lat;
    end else if (waitCnt != 0) begin
      waitCnt <= waitCnt - 1;
      if (waitCnt == 1) begin
        modelValid <= 1'b1;
        modelData  <= (rspIdx < scriptLen) ? script[rspIdx] : script[scriptLen-1];
        rspIdx     <= rspIdx + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic resetModel();
    @(negedge clk);
    clearModel = 1'b1;
    @(negedge clk);
    clearModel = 1'b0;
  endtask

  // Run one operation; a second start may be injected while busy (R8)
  task automatic runOp(input logic [7:0] ex, input logic [ADDR_W-1:0] ad,
                       input bit expPass, input int expReads, input bit midStart);
    int cyc;
    int busyErr;
    resetModel();
    curAddr   = ad;
    expData   = ex;
    validAddr = ad;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    chk(busy === 1'b1 && rdReq === 1'b1, "R6 busy/rdReq one cycle after start", int'(busy), 1);
    busyErr = 0;
    cyc = 0;
    while (done !== 1'b1 && cyc < 500) begin
      if (busy !== 1'b1) busyErr++;
      if (midStart && cyc == 1) begin
        expData   = ~ex;
        validAddr = ~ad;
        start     = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done === 1'b1, "R5 done reached", int'(done), 1);
    chk(busyErr == 0, "R6 busy held until done", busyErr, 0);
    chk(busy === 1'b0, "R5 busy low with done", int'(busy), 0);
    chk(pass === expPass, "R2/R4 verdict", int'(pass), int'(expPass));
    chk(reqCount == expReads, "R3/R4/R7 read count", reqCount, expReads);
    chk(addrErr == 0, "R1/R8 read address", addrErr, 0);
    @(negedge clk);
    chk(done === 1'b0, "R5 done single cycle", int'(done), 0);
    chk(reqCount == expReads, "R1 no read after done", reqCount, expReads);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy === 1'b0, "R10 busy in reset", int'(busy), 0);
    chk(done === 1'b0, "R10 done in reset", int'(done), 0);
    chk(rdReq === 1'b0, "R10 rdReq in reset", int'(rdReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && rdReq === 1'b0, "R10 idle after reset", int'(busy), 0);

    // Table-driven cases: R2, R3, R4
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 4; k++) script[k] = V_RSP[i][k];
      scriptLen = V_LEN[i];
      lat       = V_LAT[i];
      runOp(V_EXP[i], ADDR_W'(24'h100000 + i * 24'h1234), V_PASS[i], V_READS[i], 1'b0);
    end

    // R7: device never answers, limit of MAXP reads then fail
    script[0] = 8'h00; scriptLen = 1; lat = 1;
    runOp(8'h80, 24'hABCDE0, 1'b0, MAXP, 1'b0);

    // R8: start while busy must not relatch byte or address
    script[0] = 8'h00; script[1] = 8'h00; script[2] = 8'h80; scriptLen = 3; lat = 3;
    runOp(8'h80, 24'h055AA0, 1'b1, 3, 1'b1);

    // R9: stray response while idle
    @(negedge clk);
    strayData = 8'h80;
    stray     = 1'b1;
    @(negedge clk);
    stray     = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(busy === 1'b0 && done === 1'b0 && rdReq === 1'b0,
          "R9 stray rdValid ignored", int'({busy, done, rdReq}), 0);
      @(negedge clk);
    end
    script[0] = 8'h00; script[1] = 8'h80; scriptLen = 2; lat = 1;
    runOp(8'h80, 24'h000010, 1'b1, 2, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule